// File: doc/BRIEF.md
# Disk Device Write-by-DMA Command Sequencer

This block is the device-side controller for the disk write command that moves data over DMA. The host loads an eight-byte register set of starting address, sector count and drive/head byte, then writes the command byte. When the opcode is one of the two DMA write codes and the drive-select bit names this device, the sequencer goes busy and raises a DMA request. It takes 16-bit words from the host while the host acknowledges and strobes, and hands each word on to the media side.

At the end of every sector the sequencer drops its request and gives the media side one cycle to report an unrecoverable fault. A clean sector decrements the count and, if more sectors are left, steps the address in linear-block or cylinder/head/sector order. A fault stops the command at once. No interrupt is raised per sector. The block posts status and raises its interrupt once, when the command ends, and the address registers then hold the last sector written or the failing one. Reading the status register clears the interrupt.

Top module: `ata_wdma_seq`

## Requirements
- R1: A write of opcode 0xCA or 0xCB to register offset 7 while idle, with drive/head bit 4 equal to the DEV_SEL parameter, starts the command. From the next cycle the status (offset 7 read) is 0x88: BSY is bit 7, DRQ is bit 3, and DRDY (bit 6) is clear. The request output dmaReq is high during the transfer.
- R2: A command write with any other opcode, or with drive/head bit 4 not equal to DEV_SEL, is ignored. Status, interrupt, request and the address registers keep their values.
- R3: A word is taken only in a cycle where dmaReq, dmaAck and dmaWrStb are all high. The word appears on mediaWord, with mediaValid high in that same cycle. With dmaAck low, no word moves even though dmaReq stays high.
- R4: Each sector is WORDS words. After the last word of a sector, dmaReq is low and mediaCheck is high for exactly one cycle, in which mediaErr is sampled.
- R5: When drive/head bit 6 is 1, the address is the 28-bit value {drive/head[3:0], offset 5, offset 4, offset 3}, and it is incremented by one between sectors.
- R6: When drive/head bit 6 is 0, the sector number (offset 3) counts from 1 to SPT and wraps to 1 with a head increment. The head (drive/head[3:0]) wraps from HEADS-1 to 0 with a 16-bit cylinder {offset 5, offset 4} increment.
- R7: A sector count (offset 2) of 0 transfers 256 sectors.
- R8: On success the sector count reads 0x00 and the address registers hold the last sector written. The status reads 0x40, the error register (offset 1 read) reads 0x00, and intrq is raised once.
- R9: A mediaErr in a check cycle ends the command. dmaReq is never raised again for that command. The address holds the failing sector, and the count holds the sectors not completed, including the failing one. The status reads 0x41 (ERR is bit 0, with DRDY), the error register reads ERR_CODE, and intrq is raised.
- R10: intrq is cleared in the cycle after a host read of offset 7.
- R11: After reset the status reads 0x40, the address, count and error registers read 0, and intrq and dmaReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hostAddr | input | 3 | Register offset |
| hostWrData | input | 8 | Register write data |
| hostWr | input | 1 | Register write strobe |
| hostRd | input | 1 | Register read strobe |
| hostRdData | output | 8 | Register read data (combinational) |
| dmaReq | output | 1 | DMA request from device |
| dmaAck | input | 1 | DMA acknowledge from host |
| dmaWrStb | input | 1 | Host write strobe for a data word |
| dmaData | input | 16 | Data word from host |
| mediaWord | output | 16 | Word passed to media |
| mediaValid | output | 1 | mediaWord is taken this cycle |
| mediaCheck | output | 1 | Sector-end check cycle |
| mediaErr | input | 1 | Unrecoverable fault for the checked sector |
| intrq | output | 1 | Completion interrupt |

## Verification
Read data is combinational, so register values are sampled on the falling edge of the same cycle as the read. dmaReq rises in the first cycle after the edge that takes the command byte. mediaCheck follows the edge that takes a sector's last word. intrq and the final status appear one edge after the check cycle, and intrq falls one edge after the status read. The bench moves host signals just after each rising edge, and counts words and samples outputs on falling edges. It then compares the moved-word totals, final registers and interrupt state with values computed from the requirements.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_CHECK} seqState_t;

  typedef struct packed {
    logic accept;
    logic take;
    logic decCount;
    logic advAddr;
    logic setErr;
  } dpStrobes_t;

  localparam logic [2:0] OFS_ERR = 3'd1;
  localparam logic [2:0] OFS_CNT = 3'd2;
  localparam logic [2:0] OFS_SEC = 3'd3;
  localparam logic [2:0] OFS_CYL_LO = 3'd4;
  localparam logic [2:0] OFS_CYL_HI = 3'd5;
  localparam logic [2:0] OFS_DRVHD = 3'd6;
  localparam logic [2:0] OFS_CMD = 3'd7;
endpackage

// File: rtl/wdma_ctrl.sv
module wdma_ctrl
  import wdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdGo,
  input  logic       wordLast,
  input  logic       remainOne,
  input  logic       dmaAck,
  input  logic       dmaWrStb,
  input  logic       mediaErr,
  input  logic       statusRead,
  output dpStrobes_t str,
  output logic       busy,
  output logic       drq,
  output logic       errBit,
  output logic       intrq,
  output logic       dmaReq,
  output logic       mediaCheck
);
  seqState_t state, stateNext;
  logic errFlag;
  logic finish;

  always_comb begin
    stateNext = state;
    str = '0;
    finish = 1'b0;
    case (state)
      ST_IDLE: if (cmdGo) begin
        str.accept = 1'b1;
        stateNext = ST_XFER;
      end
      ST_XFER: begin
        str.take = dmaAck && dmaWrStb;
        if (str.take && wordLast) stateNext = ST_CHECK;
      end
      ST_CHECK: begin
        if (mediaErr) begin
          str.setErr = 1'b1;
          finish = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          str.decCount = 1'b1;
          if (remainOne) begin
            finish = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            str.advAddr = 1'b1;
            stateNext = ST_XFER;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      errFlag <= 1'b0;
      intrq <= 1'b0;
    end else begin
      state <= stateNext;
      if (str.accept) errFlag <= 1'b0;
      else if (str.setErr) errFlag <= 1'b1;
      if (finish) intrq <= 1'b1;
      else if (statusRead || str.accept) intrq <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);
  assign drq = (state == ST_XFER);
  assign dmaReq = (state == ST_XFER);
  assign mediaCheck = (state == ST_CHECK);
  assign errBit = errFlag && !busy;

  // R8
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intrq) |-> $fell(busy));

  // R4
  single_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mediaCheck |=> !mediaCheck);

  // R9
  halt_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mediaCheck && mediaErr) |=> (!dmaReq && intrq));
endmodule

// File: rtl/wdma_dp.sv
module wdma_dp
  import wdma_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int HEADS = 16,
  parameter int SPT = 63,
  parameter logic [7:0] ERR_CODE = 8'h40,
  parameter logic DEV_SEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hostAddr,
  input  logic [7:0] hostWrData,
  input  logic       hostWr,
  input  dpStrobes_t str,
  input  logic       busy,
  input  logic       drq,
  input  logic       errBit,
  output logic [7:0] hostRdData,
  output logic       cmdGo,
  output logic       wordLast,
  output logic       remainOne
);
  localparam int WW = (WORDS > 2) ? $clog2(WORDS) : 1;
  localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);
  localparam logic [3:0] LAST_HEAD = 4'(HEADS - 1);
  localparam logic [7:0] LAST_SEC = 8'(SPT);

  logic [7:0] secReg, cylLo, cylHi, drvHd, errReg;
  logic [8:0] remain;
  logic [WW-1:0] wordCnt;
  logic [27:0] lbaNext;
  logic [15:0] cylNext;
  logic regWr;

  assign regWr = hostWr && !busy;
  assign cmdGo = regWr && (hostAddr == OFS_CMD) && (drvHd[4] == DEV_SEL)
                 && (hostWrData == 8'hCA || hostWrData == 8'hCB);
  assign wordLast = (wordCnt == LAST_WORD);
  assign remainOne = (remain == 9'd1);
  assign lbaNext = {drvHd[3:0], cylHi, cylLo, secReg} + 28'd1;
  assign cylNext = {cylHi, cylLo} + 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secReg <= '0; cylLo <= '0; cylHi <= '0; drvHd <= '0;
      errReg <= '0; remain <= '0; wordCnt <= '0;
    end else begin
      if (regWr) begin
        case (hostAddr)
          OFS_CNT:    remain <= (hostWrData == 8'd0) ? 9'd256 : {1'b0, hostWrData};
          OFS_SEC:    secReg <= hostWrData;
          OFS_CYL_LO: cylLo <= hostWrData;
          OFS_CYL_HI: cylHi <= hostWrData;
          OFS_DRVHD:  drvHd <= hostWrData;
          default: ;
        endcase
      end
      if (str.accept) begin
        errReg <= '0;
        wordCnt <= '0;
      end
      if (str.setErr) errReg <= ERR_CODE;
      if (str.take) wordCnt <= wordLast ? '0 : wordCnt + 1'b1;
      if (str.decCount) remain <= remain - 9'd1;
      if (str.advAddr) begin
        if (drvHd[6]) begin
          {drvHd[3:0], cylHi, cylLo, secReg} <= lbaNext;
        end else if (secReg >= LAST_SEC) begin
          secReg <= 8'd1;
          if (drvHd[3:0] >= LAST_HEAD) begin
            drvHd[3:0] <= 4'd0;
            {cylHi, cylLo} <= cylNext;
          end else begin
            drvHd[3:0] <= drvHd[3:0] + 4'd1;
          end
        end else begin
          secReg <= secReg + 8'd1;
        end
      end
    end
  end

  always_comb begin
    case (hostAddr)
      OFS_ERR:    hostRdData = errReg;
      OFS_CNT:    hostRdData = remain[7:0];
      OFS_SEC:    hostRdData = secReg;
      OFS_CYL_LO: hostRdData = cylLo;
      OFS_CYL_HI: hostRdData = cylHi;
      OFS_DRVHD:  hostRdData = drvHd;
      OFS_CMD:    hostRdData = {busy, !busy, 2'b00, drq, 2'b00, errBit};
      default:    hostRdData = 8'h00;
    endcase
  end

  // R4
  word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wordCnt <= LAST_WORD);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (str.take || str.decCount) |-> (remain != 9'd0));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !str.advAddr) |=> $stable(secReg));
endmodule

// File: rtl/ata_wdma_seq.sv
module ata_wdma_seq
  import wdma_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int HEADS = 16,
  parameter int SPT = 63,
  parameter logic [7:0] ERR_CODE = 8'h40,
  parameter logic DEV_SEL = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  input  logic        hostWr,
  input  logic        hostRd,
  output logic [7:0]  hostRdData,
  output logic        dmaReq,
  input  logic        dmaAck,
  input  logic        dmaWrStb,
  input  logic [15:0] dmaData,
  output logic [15:0] mediaWord,
  output logic        mediaValid,
  output logic        mediaCheck,
  input  logic        mediaErr,
  output logic        intrq
);
  dpStrobes_t str;
  logic busy, drq, errBit, cmdGo, wordLast, remainOne, statusRead;

  assign statusRead = hostRd && (hostAddr == OFS_CMD);
  assign mediaWord = dmaData;
  assign mediaValid = str.take;

  wdma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdGo(cmdGo), .wordLast(wordLast),
    .remainOne(remainOne), .dmaAck(dmaAck), .dmaWrStb(dmaWrStb),
    .mediaErr(mediaErr), .statusRead(statusRead), .str(str), .busy(busy),
    .drq(drq), .errBit(errBit), .intrq(intrq), .dmaReq(dmaReq),
    .mediaCheck(mediaCheck)
  );

  wdma_dp #(.WORDS(WORDS), .HEADS(HEADS), .SPT(SPT), .ERR_CODE(ERR_CODE),
            .DEV_SEL(DEV_SEL)) u_dp (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostWr(hostWr), .str(str), .busy(busy), .drq(drq), .errBit(errBit),
    .hostRdData(hostRdData), .cmdGo(cmdGo), .wordLast(wordLast),
    .remainOne(remainOne)
  );

  // R3
  take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mediaValid |-> (dmaReq && dmaAck && dmaWrStb));
endmodule

// File: tb/ata_wdma_seq_test.sv
module ata_wdma_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] hostAddr = 0;
  logic [7:0] hostWrData = 0;
  logic hostWr = 0, hostRd = 0;
  logic [7:0] hostRdData;
  logic dmaReq, dmaAck = 0, dmaWrStb = 0;
  logic [15:0] dmaData = 0;
  logic [15:0] mediaWord;
  logic mediaValid, mediaCheck, mediaErr = 0, intrq;

  int checks = 0, fails = 0, words = 0, secIdx = 0, errTarget = 999;
  int cycles = 0;
  logic hostEn = 0, gappy = 0, toggle = 0;
  logic [7:0] v;

  ata_wdma_seq #(.WORDS(WORDS), .HEADS(4), .SPT(3), .ERR_CODE(8'h40),
                 .DEV_SEL(1'b0)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    toggle = ~toggle;
    dmaAck = hostEn;
    dmaWrStb = hostEn && (!gappy || toggle);
    dmaData = dmaData + 16'd1;
  end

  always @(negedge clk) begin
    if (mediaValid) words++;
    mediaErr = mediaCheck && (secIdx == errTarget);
    if (mediaCheck) secIdx++;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1 hostAddr = a; hostWrData = d; hostWr = 1;
    @(posedge clk); #1 hostWr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #1 hostAddr = a; hostRd = 1;
    @(negedge clk); d = hostRdData;
    @(posedge clk); #1 hostRd = 0;
  endtask

  task automatic waitIrq();
    while (!intrq) @(negedge clk);
  endtask

  task automatic prep(input int tgt);
    words = 0; secIdx = 0; errTarget = tgt;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 intrq", intrq, 0);
    chk("R11 dmaReq", dmaReq, 0);
    rd(3'd7, v); chk("R11 status", v, 8'h40);
    rd(3'd3, v); chk("R11 sector", v, 0);
    rd(3'd2, v); chk("R11 count", v, 0);
    rd(3'd1, v); chk("R11 error", v, 0);
  endtask

  task automatic t_lba();
    prep(999);
    wr(3'd6, 8'hE0); wr(3'd3, 8'hFE); wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    wr(3'd2, 8'h03); wr(3'd7, 8'hCA);
    rd(3'd7, v); chk("R1 busy status", v, 8'h88);
    repeat (5) @(negedge clk);
    chk("R1 dmaReq", dmaReq, 1);
    chk("R3 no ack no words", words, 0);
    hostEn = 1;
    waitIrq();
    hostEn = 0;
    chk("R4 lba words", words, 12);
    rd(3'd3, v); chk("R5 sector", v, 8'h00);
    rd(3'd4, v); chk("R5 cyl lo", v, 8'h35);
    rd(3'd5, v); chk("R5 cyl hi", v, 8'h12);
    rd(3'd6, v); chk("R5 drvhd", v, 8'hE0);
    rd(3'd2, v); chk("R8 count", v, 8'h00);
    rd(3'd1, v); chk("R8 error", v, 8'h00);
    chk("R8 intrq", intrq, 1);
    rd(3'd7, v); chk("R8 status", v, 8'h40);
    @(negedge clk); chk("R10 intrq cleared", intrq, 0);
  endtask

  task automatic t_chs();
    prep(999);
    wr(3'd6, 8'hA3); wr(3'd3, 8'h02); wr(3'd4, 8'hFF); wr(3'd5, 8'h00);
    wr(3'd2, 8'h04); wr(3'd7, 8'hCB);
    hostEn = 1;
    waitIrq();
    hostEn = 0;
    chk("R6 words", words, 16);
    chk("R4 checks", secIdx, 4);
    rd(3'd3, v); chk("R6 sector", v, 8'h02);
    rd(3'd4, v); chk("R6 cyl lo", v, 8'h00);
    rd(3'd5, v); chk("R6 cyl hi", v, 8'h01);
    rd(3'd6, v); chk("R6 drvhd", v, 8'hA0);
    rd(3'd7, v); chk("R8 chs status", v, 8'h40);
  endtask

  task automatic t_err();
    prep(1);
    wr(3'd6, 8'hE0); wr(3'd3, 8'h10); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd2, 8'h05); wr(3'd7, 8'hCA);
    hostEn = 1;
    waitIrq();
    repeat (10) @(negedge clk);
    chk("R9 dmaReq low", dmaReq, 0);
    hostEn = 0;
    chk("R9 words", words, 8);
    rd(3'd3, v); chk("R9 failing sector", v, 8'h11);
    rd(3'd2, v); chk("R9 count", v, 8'h04);
    rd(3'd1, v); chk("R9 error code", v, 8'h40);
    rd(3'd7, v); chk("R9 status", v, 8'h41);
  endtask

  task automatic t_ignored();
    prep(999);
    wr(3'd6, 8'hF0); wr(3'd7, 8'hCA);
    repeat (3) @(negedge clk);
    chk("R2 wrong dev dmaReq", dmaReq, 0);
    chk("R2 wrong dev intrq", intrq, 0);
    rd(3'd7, v); chk("R2 wrong dev status", v, 8'h41);
    wr(3'd6, 8'hE0); wr(3'd7, 8'h20);
    repeat (3) @(negedge clk);
    chk("R2 bad opcode dmaReq", dmaReq, 0);
    rd(3'd7, v); chk("R2 bad opcode status", v, 8'h41);
    rd(3'd3, v); chk("R2 sector kept", v, 8'h11);
  endtask

  task automatic t_full();
    prep(999);
    gappy = 1;
    wr(3'd6, 8'hE0); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd2, 8'h00); wr(3'd7, 8'hCB);
    hostEn = 1;
    waitIrq();
    hostEn = 0; gappy = 0;
    chk("R7 words", words, 256 * WORDS);
    rd(3'd3, v); chk("R7 last sector", v, 8'hFF);
    rd(3'd2, v); chk("R7 count", v, 8'h00);
    rd(3'd1, v); chk("R8 error cleared", v, 8'h00);
    rd(3'd7, v); chk("R7 status", v, 8'h40);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_lba();
    t_chs();
    t_err();
    t_ignored();
    t_full();
    summary();
  end
endmodule